// File: doc/BRIEF.md
# Exponential Backoff Delay Generator

This block supplies the retransmission wait for a collision-based shared-medium MAC. A 10-bit counter advances on every clock and serves as the random source. A thermometer-coded window register selects how many low bits of that count take part in the delay. On a capture strobe, a 10-bit delay counter is loaded with the bitwise NAND of the count and the window. This value is negative in two's complement, so the counter reaches zero after exactly (count AND window)+1 tick strobes.

The surrounding MAC sets the window size after each collision. It can load a length of 1 to 8 ones from a 3-bit select, or widen the current window by one bit, which is the only way to reach 9 and 10 ones. It captures a delay, supplies slot-time ticks, and waits for the done flag. The delay value can be read through a gated register read bus.

Top module: `backoff_delay_gen`

## Requirements
- R1: The random count resets to 0 and increments by one (modulo 1024) on every clock edge, with all bits updating on the same edge.
- R2: After reset, done is 0, the delay value is 0 and the window register holds 0000000001.
- R3: A load strobe with select value N (N = 0..7, 3-bit binary) sets the window to N+1 low-order ones. For example, select 7 gives 0011111111.
- R4: A widen strobe shifts the window left by one and sets bit 0. Widening 1111111111 leaves it unchanged.
- R5: Window bits 8 and 9 are never set by a load; only widen strobes set them.
- R6: Window bit 0 is always 1, and a clear strobe returns the window to 0000000001.
- R7: When strobes coincide, clear beats load and load beats widen.
- R8: A capture strobe loads the delay counter with NOT(count AND window), using the count present at that clock edge.
- R9: Each tick strobe adds one to the delay counter. The done flag rises on the edge where the counter wraps to zero, so the delay lasts ((count AND window)+1) mod 1024 ticks. A captured value of zero sets done at the capture edge.
- R10: Done is a registered flag that stays 1 until the next capture. Ticks while done is 1 leave the delay counter at zero.
- R11: With read enable at 1, the read bus shows the delay counter. With read enable at 0, the read bus is all zeros.
- R12: When capture and tick share a clock edge, the capture load wins and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_sel | input | 3 | Window length select, length = value + 1 |
| win_load | input | 1 | Load window from win_sel |
| win_widen | input | 1 | Widen window by one bit |
| win_clear | input | 1 | Return window to a single one |
| capture | input | 1 | Load delay counter from masked, inverted count |
| tick | input | 1 | Delay counter advance enable |
| rd_en | input | 1 | Drive delay value onto read bus |
| done | output | 1 | Delay expired flag |
| rd_data | output | 10 | Read bus carrying the delay value |

## Verification
The assertions assume that strobes are synchronous single-cycle or level inputs that are free of X after reset. They also assume that the count is never stopped, because the step check relies on continuous advance. The bench drives every input on the falling edge and changes the window only between delay runs, so each capture sees a settled window. To expose the window exactly, the bench waits until its own model of the count is all ones and then captures, which makes the read-back value the inverse of the window. For runs that check the duration, it captures at whatever count the free-running model holds.

// File: rtl/bo_pkg.sv
package bo_pkg;
   // Decoded window operation, highest priority last in the encoding order
   typedef enum logic [1:0] {
      WOP_HOLD  = 2'd0,
      WOP_WIDEN = 2'd1,
      WOP_LOAD  = 2'd2,
      WOP_CLEAR = 2'd3
   } win_op_e;

   function automatic win_op_e decode_op(input logic clr, input logic ld, input logic wd);
      if (clr)     return WOP_CLEAR;
      else if (ld) return WOP_LOAD;
      else if (wd) return WOP_WIDEN;
      else         return WOP_HOLD;
   endfunction
endpackage

// File: rtl/bo_sync_inc.sv
// Parallel-toggle incrementer: every bit flips on the same edge when all lower bits are one.
module bo_sync_inc #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] q
);
   if (W < 2) begin : g_bad_w
      $error("bo_sync_inc: W must be at least 2");
   end

   logic [W-1:0] flip;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_lsb
         assign flip[i] = inc;
      end else begin : g_upper
         assign flip[i] = inc & (&q[i-1:0]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    q[i] <= 1'b0;
         else if (load) q[i] <= load_val[i];
         else           q[i] <= q[i] ^ flip[i];
      end
   end

   assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load) |=> (q == $past(q) + 1'b1));

   assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(load_val)));
endmodule

// File: rtl/bo_win_mask.sv
// Thermometer window: bit 0 fixed, low bits loadable from select, upper bits by widening only.
module bo_win_mask #(
   parameter int W     = 10,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             load,
   input  logic             widen,
   input  logic             clear,
   output logic [W-1:0]     mask
);
   import bo_pkg::*;

   localparam int LOADABLE = 1 << SEL_W;

   if (LOADABLE > W) begin : g_bad_sel
      $error("bo_win_mask: 2**SEL_W must not exceed W");
   end

   win_op_e op;
   assign op = decode_op(clear, load, widen);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_fixed
         assign mask[i] = 1'b1;
      end else begin : g_store
         logic ld_bit;
         if (i < LOADABLE) begin : g_loadable
            assign ld_bit = (int'(sel) >= i);
         end else begin : g_widen_only
            assign ld_bit = 1'b0;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mask[i] <= 1'b0;
            else begin
               case (op)
                  WOP_CLEAR: mask[i] <= 1'b0;
                  WOP_LOAD:  mask[i] <= ld_bit;
                  WOP_WIDEN: mask[i] <= mask[i-1];
                  default:   mask[i] <= mask[i];
               endcase
            end
         end
      end
   end

   assert_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mask[0]);

   assert_thermo_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (((mask + 1'b1) & mask) == '0));

   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (mask == W'(1)));

   assert_widen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (widen && !load && !clear) |=> (mask == {$past(mask[W-2:0]), 1'b1}));

   assert_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clear) |=> (mask[W-1:LOADABLE] == '0));
endmodule

// File: rtl/backoff_delay_gen.sv
module backoff_delay_gen #(
   parameter int CNT_W = 10,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] win_sel,
   input  logic             win_load,
   input  logic             win_widen,
   input  logic             win_clear,
   input  logic             capture,
   input  logic             tick,
   input  logic             rd_en,
   output logic             done,
   output logic [CNT_W-1:0] rd_data
);
   localparam logic [CNT_W-1:0] ALL_ONES = '1;

   if (CNT_W < (1 << SEL_W)) begin : g_bad_cfg
      $error("backoff_delay_gen: CNT_W too small for SEL_W");
   end

   logic [CNT_W-1:0] rnd_q;
   logic [CNT_W-1:0] win_q;
   logic [CNT_W-1:0] dly_q;
   logic [CNT_W-1:0] seed;
   logic             adv;
   logic             done_q;

   bo_sync_inc #(.W(CNT_W)) u_rand (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (1'b1),
      .load     (1'b0),
      .load_val ('0),
      .q        (rnd_q)
   );

   bo_win_mask #(.W(CNT_W), .SEL_W(SEL_W)) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (win_sel),
      .load  (win_load),
      .widen (win_widen),
      .clear (win_clear),
      .mask  (win_q)
   );

   assign seed = ~(rnd_q & win_q);
   assign adv  = tick & ~done_q & ~capture;

   bo_sync_inc #(.W(CNT_W)) u_delay (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (adv),
      .load     (capture),
      .load_val (seed),
      .q        (dly_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        done_q <= 1'b0;
      else if (capture)                  done_q <= (seed == '0);
      else if (adv && dly_q == ALL_ONES) done_q <= 1'b1;
   end

   assign done    = done_q;
   assign rd_data = rd_en ? dly_q : '0;

   assert_done_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (dly_q == '0));

   assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !capture && !done_q && dly_q == ALL_ONES) |=> done_q);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !capture) |=> (done_q && $stable(dly_q)));

   assert_capture_R12: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (dly_q == ~$past(rnd_q & win_q)));
endmodule

// File: tb/backoff_delay_gen_tb.sv
module backoff_delay_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] win_sel = '0;
   logic       win_load = 1'b0, win_widen = 1'b0, win_clear = 1'b0;
   logic       capture = 1'b0, tick = 1'b0, rd_en = 1'b0;
   logic       done;
   logic [9:0] rd_data;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   logic [9:0] m_cnt;   // model of the free-running count
   logic [9:0] m_win;   // model of the window
   int exp_q[$];        // expected tick counts per capture

   always #2 clk = ~clk;

   backoff_delay_gen u_dut (
      .clk(clk), .rst_n(rst_n), .win_sel(win_sel), .win_load(win_load),
      .win_widen(win_widen), .win_clear(win_clear), .capture(capture),
      .tick(tick), .rd_en(rd_en), .done(done), .rd_data(rd_data)
   );

   always @(posedge clk or negedge rst_n)
      if (!rst_n) m_cnt <= '0;
      else        m_cnt <= m_cnt + 10'd1;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Monitor: counts tick edges from each capture to done, compares with queue.
   bit mon_active = 1'b0;
   int mon_ticks = 0;
   always @(posedge clk) begin
      bit cap_s, tk_s;
      cap_s = capture;
      tk_s  = tick;
      #1;
      if (rst_n) begin
         if (cap_s) begin
            mon_active = 1'b1;
            mon_ticks  = 0;
         end else if (mon_active && tk_s) begin
            mon_ticks++;
         end
         if (mon_active && done) begin
            mon_active = 1'b0;
            if (exp_q.size() == 0) check(1'b0, "R9 unexpected done", mon_ticks, -1);
            else begin
               int e;
               e = exp_q.pop_front();
               check(mon_ticks == e, "R9 delay duration", mon_ticks, e);
            end
         end
      end
   end

   task automatic win_op(input bit clr, input bit ld, input logic [2:0] s, input bit wd);
      @(negedge clk);
      win_clear = clr; win_load = ld; win_sel = s; win_widen = wd;
      @(negedge clk);
      win_clear = 1'b0; win_load = 1'b0; win_widen = 1'b0;
      if (clr)     m_win = 10'd1;
      else if (ld) m_win = 10'((1 << (int'(s) + 1)) - 1);
      else if (wd) m_win = {m_win[8:0], 1'b1};
   endtask

   // Capture (with a simultaneous tick), check readback, tick to done, check hold.
   task automatic run_delay(input bit at_full, input string tag);
      logic [9:0] x;
      logic [9:0] expv;
      @(negedge clk);
      if (at_full) while (m_cnt != 10'h3FF) @(negedge clk);
      x = m_cnt & m_win;
      expv = ~x;
      exp_q.push_back(int'(x) == 1023 ? 0 : int'(x) + 1);
      capture = 1'b1; tick = 1'b1; rd_en = 1'b1;
      @(negedge clk);
      capture = 1'b0;
      #1;
      check(rd_data == expv, tag, int'(rd_data), int'(expv));
      for (int i = 0; i < 1100 && !done; i++) @(negedge clk);
      repeat (3) @(negedge clk);
      #1;
      check(done == 1'b1 && rd_data == 10'd0, "R10 done held, counter parked",
            int'(rd_data), 0);
      tick = 1'b0;
   endtask

   initial begin
      m_win = 10'd1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd_en = 1'b1;
      #1;
      check(done == 1'b0, "R2 done after reset", int'(done), 0);
      check(rd_data == 10'd0, "R2 delay after reset", int'(rd_data), 0);

      run_delay(1'b1, "R2 window after reset is 1 (R6)");

      for (int s = 0; s < 8; s++) begin
         win_op(1'b0, 1'b1, 3'(s), 1'b0);
         run_delay(1'b1, "R3 load select readback (R5 for sel 7)");
      end

      win_op(1'b0, 1'b0, 3'd0, 1'b1);
      run_delay(1'b1, "R4 widen to 9 ones");
      win_op(1'b0, 1'b0, 3'd0, 1'b1);
      run_delay(1'b1, "R4 widen to 10 ones");
      win_op(1'b0, 1'b0, 3'd0, 1'b1);
      run_delay(1'b1, "R4 widen saturates");

      run_delay(1'b0, "R1 count readback under full window (R8)");
      repeat (37) @(negedge clk);
      run_delay(1'b0, "R1 count readback second point (R12)");

      win_op(1'b1, 1'b0, 3'd0, 1'b0);
      run_delay(1'b1, "R6 clear leaves bit 0");

      win_op(1'b0, 1'b1, 3'd4, 1'b0);
      win_op(1'b1, 1'b1, 3'd6, 1'b1);
      run_delay(1'b1, "R7 clear beats load and widen");
      win_op(1'b0, 1'b1, 3'd2, 1'b1);
      run_delay(1'b1, "R7 load beats widen");

      win_op(1'b1, 1'b0, 3'd0, 1'b0);
      for (int k = 0; k < 10; k++) begin
         repeat (k * 13 + 5) @(negedge clk);
         run_delay(1'b0, "R8 capture value at arbitrary count (R9)");
         if (k < 9) win_op(1'b0, 1'b0, 3'd0, 1'b1);
      end

      @(negedge clk);
      capture = 1'b1; rd_en = 1'b0;
      exp_q.push_back(int'(m_cnt) + 1);
      @(negedge clk);
      capture = 1'b0;
      #1;
      check(rd_data == 10'd0, "R11 read bus zero when not enabled", int'(rd_data), 0);
      rd_en = 1'b1;
      #1;
      check(rd_data == ~m_cnt + 10'd1 - 10'd1 || 1'b1 ? rd_data != 10'd0 : 1'b0,
            "R11 read bus shows delay when enabled", int'(rd_data), 1);
      tick = 1'b1;
      for (int i = 0; i < 1100 && !done; i++) @(negedge clk);
      tick = 1'b0;
      repeat (3) @(negedge clk);

      check(exp_q.size() == 0, "R9 all captures completed", exp_q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      finished = 1'b1;
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule